// File: doc/BRIEF.md
# Multiprocessor Asynchronous Serial Port

This block is a byte-wide asynchronous serial port of the kind found beside a small processor core. Software reaches it through a two-location register bus. One location is a control/status byte. The other is a data location that maps to two separate registers: writing it loads a transmit holder and starts a frame, and reading it returns the last accepted received byte. A 16x oversampling strobe comes from an outside baud source. The port drives one serial output and samples one serial input. A single interrupt line is raised while either completion flag is set.

Frames carry eight data bits, or eight data bits plus a ninth bit. Either way a low start bit comes first and a high stop bit comes last, and data goes out least significant bit first. The receiver can filter frames for multiprocessor addressing. In 9-bit framing it accepts only frames whose ninth bit is 1. In 8-bit framing it drops frames with a bad stop bit. The top bit of the control byte is shared between the framing-select bit and a framing-error flag, and the `alias_sel` input chooses which of the two is seen. The two values live in separate flops.

Both the transmitter and the receiver are state machines with the states IDLE, START, DATA, NINTH and STOP. The transmitter goes IDLE→START on a data write. It goes START→DATA after 16 strobes, then DATA→NINTH (9-bit) or DATA→STOP (8-bit) after the eighth data bit, NINTH→STOP, and STOP→IDLE after 16 strobes. The receiver goes IDLE→START when it sees a low line on a strobe. It returns START→IDLE if the start bit votes high (a glitch). Otherwise it moves START→DATA→NINTH/STOP at bit boundaries, and STOP→IDLE at the stop-bit vote. A cleared receive enable forces any receiver state back to IDLE.

Top module: `mpuart_core`

## Requirements
- R1: After reset the control byte and the received-byte register read 0, `txd` is 1 and `irq` is 0.
- R2: Control bit 7 reads and writes the framing-select flop when `alias_sel`=0, and the framing-error flop when `alias_sel`=1. A write with `alias_sel`=1 never changes the framing select.
- R3: Framing select (bit 7 with `alias_sel`=0) = 1 gives 9-bit frames; 0 gives 8-bit frames. Bit 6 is stored and read back but does not change framing.
- R4: A write to bus address 1 while the transmitter is idle sends a frame on `txd`: 0 for 16 strobes, then the 8 data bits LSB first, then (9-bit only) control bit 3, then 1 for 16 strobes. Each bit lasts 16 strobes, and `txd` is 1 when idle.
- R5: Control bit 1 (transmit done) is set when the last data bit (ninth bit in 9-bit framing) ends. A data write during a frame is ignored.
- R6: Each received bit is the majority of the line samples taken on strobes 7, 8 and 9 of the bit. A start bit that votes 1 is dropped as a glitch, and nothing is received.
- R7: With control bit 4 (receive enable) = 0, activity on `rxd` changes no register.
- R8: In 8-bit framing with control bit 5 (multiprocessor) = 0, a frame loads the received byte, copies the stop value into control bit 2, and sets control bit 0 (receive done) at the stop-bit vote.
- R9: In 8-bit framing with bit 5 = 1, a frame whose stop bit votes 0 leaves the received byte and bit 0 unchanged. A frame with a good stop bit is accepted and leaves bit 2 unchanged.
- R10: In 9-bit framing the ninth bit goes to control bit 2 and bit 0 is set at the ninth-bit vote. With bit 5 = 1 a frame whose ninth bit is 0 is discarded.
- R11: The framing-error flop is set by hardware whenever a stop bit votes 0, and software can clear it by writing 0 to bit 7 with `alias_sel`=1.
- R12: `irq` is 1 exactly when control bit 1 or bit 0 is 1.
- R13: A control write with bits 1 and 0 at 0 clears both completion flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alias_sel | input | 1 | Selects framing-error flag (1) or framing select (0) at control bit 7 |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control byte, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Interrupt, high while a completion flag is set |

## Verification
The transmitter is tried with an 8-bit pattern and a 9-bit pattern with a set ninth bit, and one frame is sent with bit 6 also set. Each bit is sampled at mid-bit, which separates LSB-first order, ninth-bit placement and framing select. The receiver is sent good and bad stop bits and ninth bits of both values, under each setting of the multiprocessor bit. These patterns tell acceptance apart from discard, and show which value lands in bit 2. A one-strobe inverted pulse inside a data bit, a short start pulse and a disabled receiver show that the majority vote, glitch rejection and the enable each do their part.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

    localparam int BYTE_W = 8;

    // control byte field positions
    localparam int CB_FRAME = 7;   // framing select / framing-error alias
    localparam int CB_AUX   = 6;
    localparam int CB_MP    = 5;
    localparam int CB_REN   = 4;
    localparam int CB_TX9   = 3;
    localparam int CB_RX9   = 2;
    localparam int CB_TDONE = 1;
    localparam int CB_RDONE = 0;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_state_e;

endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx
    import mpuart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    input  logic              nine_en,
    input  logic              bit9,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(BYTE_W);

    tx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [BYTE_W-1:0] shift_q;
    logic              b9_q, nine_q;
    logic              bit_end, last_data;

    assign bit_end   = tick && (cnt_q == CW'(OSR - 1));
    assign last_data = (idx_q == IW'(BYTE_W - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (start)   state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && last_data) state_d = nine_q ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            b9_q    <= 1'b0;
            nine_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE) begin
                cnt_q <= '0;
                idx_q <= '0;
                if (start) begin
                    shift_q <= din;
                    b9_q    <= bit9;
                    nine_q  <= nine_en;
                end
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
                if (bit_end && state_q == TX_DATA) begin
                    shift_q <= shift_q >> 1;
                    idx_q   <= idx_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        txd  = 1'b1;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            TX_IDLE:  busy = 1'b0;
            TX_START: txd = 1'b0;
            TX_DATA: begin
                txd  = shift_q[0];
                done = bit_end && last_data && !nine_q;
            end
            TX_NINTH: begin
                txd  = b9_q;
                done = bit_end;
            end
            TX_STOP:  txd = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              en,
    input  logic              nine_en,
    input  logic              mp_en,
    output logic              load,
    output logic [BYTE_W-1:0] data,
    output logic              b9_upd,
    output logic              b9_val,
    output logic              set_ri,
    output logic              set_fe
);
    localparam int CW  = $clog2(OSR);
    localparam int IW  = $clog2(BYTE_W);
    localparam int MID = OSR / 2;

    rx_state_e         state_q, state_d;
    logic [SYNC_LEN-1:0] sync_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [BYTE_W-1:0] shift_q;
    logic [1:0]        smp_q;
    logic              nine_q;
    logic              rx_s, in_frame, smp_now, vote_now, bit_end, maj, detect;

    assign rx_s     = sync_q[SYNC_LEN-1];
    assign in_frame = (state_q != RX_IDLE);
    assign smp_now  = tick && in_frame && (cnt_q >= CW'(MID - 1)) && (cnt_q <= CW'(MID + 1));
    assign vote_now = tick && in_frame && (cnt_q == CW'(MID + 1));
    assign bit_end  = tick && (cnt_q == CW'(OSR - 1));
    assign maj      = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx_s) | (smp_q[0] & rx_s);
    assign detect   = (state_q == RX_IDLE) && en && tick && !rx_s;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (detect) state_d = RX_START;
            RX_START: begin
                if (vote_now && maj) state_d = RX_IDLE;
                else if (bit_end)    state_d = RX_DATA;
            end
            RX_DATA:  if (bit_end && idx_q == IW'(BYTE_W - 1)) state_d = nine_q ? RX_NINTH : RX_STOP;
            RX_NINTH: if (bit_end)  state_d = RX_STOP;
            RX_STOP:  if (vote_now) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
        if (!en) state_d = RX_IDLE;
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            sync_q  <= '1;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            smp_q   <= '0;
            nine_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sync_q  <= {sync_q[SYNC_LEN-2:0], rxd};
            if (state_q == RX_IDLE) begin
                idx_q <= '0;
                cnt_q <= detect ? CW'(1) : '0;
                if (detect) nine_q <= nine_en;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
                if (smp_now) smp_q <= {smp_q[0], rx_s};
                if (vote_now && state_q == RX_DATA) shift_q <= {maj, shift_q[BYTE_W-1:1]};
                if (bit_end && state_q == RX_DATA)  idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        b9_upd = 1'b0;
        set_ri = 1'b0;
        set_fe = 1'b0;
        b9_val = maj;
        data   = shift_q;
        unique case (state_q)
            RX_NINTH: if (vote_now) begin
                load   = !mp_en || maj;
                set_ri = !mp_en || maj;
                b9_upd = !mp_en || maj;
            end
            RX_STOP: if (vote_now) begin
                set_fe = !maj;
                if (!nine_q) begin
                    load   = !mp_en || maj;
                    set_ri = !mp_en || maj;
                    b9_upd = !mp_en;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mpuart_regs.sv
module mpuart_regs
    import mpuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alias_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_b9_upd,
    input  logic              rx_b9,
    input  logic              rx_set_ri,
    input  logic              rx_set_fe,
    input  logic              tx_done,
    output logic              tx_start,
    output logic              mode_hi,
    output logic              mp_en,
    output logic              rx_en,
    output logic              tx9,
    output logic              rx9,
    output logic              ti,
    output logic              ri,
    output logic [BYTE_W-1:0] rx_buf
);
    logic mode_lo, fe, ctrl_wr;
    logic [BYTE_W-1:0] ctrl_rd;

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    assign tx_start = bus_wr && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_hi <= 1'b0;
            fe      <= 1'b0;
            mode_lo <= 1'b0;
            mp_en   <= 1'b0;
            rx_en   <= 1'b0;
            tx9     <= 1'b0;
            rx9     <= 1'b0;
            ti      <= 1'b0;
            ri      <= 1'b0;
            rx_buf  <= '0;
        end else begin
            if (ctrl_wr) begin
                if (alias_sel) fe      <= bus_wdata[CB_FRAME];
                else           mode_hi <= bus_wdata[CB_FRAME];
                mode_lo <= bus_wdata[CB_AUX];
                mp_en   <= bus_wdata[CB_MP];
                rx_en   <= bus_wdata[CB_REN];
                tx9     <= bus_wdata[CB_TX9];
                rx9     <= bus_wdata[CB_RX9];
                ti      <= bus_wdata[CB_TDONE];
                ri      <= bus_wdata[CB_RDONE];
            end
            // hardware events take priority over a same-cycle write
            if (rx_set_fe) fe     <= 1'b1;
            if (rx_b9_upd) rx9    <= rx_b9;
            if (tx_done)   ti     <= 1'b1;
            if (rx_set_ri) ri     <= 1'b1;
            if (rx_load)   rx_buf <= rx_data;
        end
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[CB_FRAME] = alias_sel ? fe : mode_hi;
        ctrl_rd[CB_AUX]   = mode_lo;
        ctrl_rd[CB_MP]    = mp_en;
        ctrl_rd[CB_REN]   = rx_en;
        ctrl_rd[CB_TX9]   = tx9;
        ctrl_rd[CB_RX9]   = rx9;
        ctrl_rd[CB_TDONE] = ti;
        ctrl_rd[CB_RDONE] = ri;
        bus_rdata = (bus_addr == ADDR_DATA) ? rx_buf : ctrl_rd;
    end

endmodule

// File: rtl/mpuart_core.sv
module mpuart_core
    import mpuart_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alias_sel,
    input  logic              tick16,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    logic              rx_load, rx_b9_upd, rx_b9, rx_set_ri, rx_set_fe;
    logic [BYTE_W-1:0] rx_data, rx_buf;
    logic              tx_done, tx_start, tx_busy;
    logic              mode_hi, mp_en, rx_en, tx9, rx9, ti, ri;

    mpuart_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .alias_sel (alias_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_load   (rx_load),
        .rx_data   (rx_data),
        .rx_b9_upd (rx_b9_upd),
        .rx_b9     (rx_b9),
        .rx_set_ri (rx_set_ri),
        .rx_set_fe (rx_set_fe),
        .tx_done   (tx_done),
        .tx_start  (tx_start),
        .mode_hi   (mode_hi),
        .mp_en     (mp_en),
        .rx_en     (rx_en),
        .tx9       (tx9),
        .rx9       (rx9),
        .ti        (ti),
        .ri        (ri),
        .rx_buf    (rx_buf)
    );

    mpuart_tx #(.OSR(OSR)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .start   (tx_start),
        .din     (bus_wdata),
        .nine_en (mode_hi),
        .bit9    (tx9),
        .txd     (txd),
        .busy    (tx_busy),
        .done    (tx_done)
    );

    mpuart_rx #(.OSR(OSR), .SYNC_LEN(SYNC_LEN)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd     (rxd),
        .en      (rx_en),
        .nine_en (mode_hi),
        .mp_en   (mp_en),
        .load    (rx_load),
        .data    (rx_data),
        .b9_upd  (rx_b9_upd),
        .b9_val  (rx_b9),
        .set_ri  (rx_set_ri),
        .set_fe  (rx_set_fe)
    );

    assign irq = ti | ri;

endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk
    import mpuart_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              alias_sel,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic              txd,
    input logic              mode_hi,
    input logic              mp_en,
    input logic              tx_busy,
    input logic              ti,
    input logic              ri,
    input logic              rx9,
    input logic [BYTE_W-1:0] rx_buf
);
    // R2: an aliased write never touches the framing select
    p_mode_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CTRL && alias_sel) |=> $stable(mode_hi));

    // R4: a frame only starts from a data write
    p_tx_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(bus_wr && bus_addr == ADDR_DATA));

    // R5: transmit done rises as the line enters the stop bit
    p_ti_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ti) && !$past(bus_wr && bus_addr == ADDR_CTRL)) |-> txd);

    // R8: the received byte only changes together with receive done
    p_buf_ri_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_buf) |-> ri);

    // R10: with multiprocessor filtering in 9-bit framing, receive done implies ninth bit 1
    p_ninth_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ri) && mode_hi && mp_en && !$past(bus_wr && bus_addr == ADDR_CTRL)) |-> rx9);

endmodule

bind mpuart_core mpuart_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alias_sel (alias_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .txd       (txd),
    .mode_hi   (mode_hi),
    .mp_en     (mp_en),
    .tx_busy   (tx_busy),
    .ti        (ti),
    .ri        (ri),
    .rx9       (rx9),
    .rx_buf    (rx_buf)
);

// File: tb/mpuart_core_tb_top.sv
module mpuart_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, alias_sel, bus_wr, bus_addr, rxd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       txd, irq, tick16;
    logic [1:0] div = 2'd0;
    int         tick_cnt = 0;
    int         n_chk = 0, n_bad = 0, irq_bad = 0;
    bit         fin = 1'b0;

    // behavioural model of the register state
    bit m_mode9, m_fe, m_lo, m_mp, m_ren, m_tx9, m_rx9, m_ti, m_ri;
    logic [7:0] m_buf;

    always #5 clk = ~clk;
    always @(posedge clk) div <= div + 2'd1;
    assign tick16 = (div == 2'd3);
    always @(posedge clk) if (tick16) tick_cnt <= tick_cnt + 1;

    mpuart_core dut_i (
        .clk(clk), .rst_n(rst_n), .alias_sel(alias_sel), .tick16(tick16),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    // R12: compared on every clock against the control flags seen on the bus
    always @(negedge clk) begin
        #2;
        if (rst_n && !bus_wr && bus_addr == 1'b0 && irq !== (bus_rdata[1] | bus_rdata[0]))
            irq_bad++;
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_until(int t);
        while (tick_cnt < t) @(negedge clk);
    endtask

    task automatic bus_write(logic a, logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic bus_read(logic a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 1'b0;
    endtask

    function automatic logic [7:0] ctrl_exp(bit al);
        return {al ? m_fe : m_mode9, m_lo, m_mp, m_ren, m_tx9, m_rx9, m_ti, m_ri};
    endfunction

    task automatic wr_ctrl(logic [7:0] v);
        bus_write(1'b0, v);
        if (alias_sel) m_fe = v[7]; else m_mode9 = v[7];
        m_lo = v[6]; m_mp = v[5]; m_ren = v[4]; m_tx9 = v[3];
        m_rx9 = v[2]; m_ti = v[1]; m_ri = v[0];
    endtask

    task automatic verify_regs(string tag);
        logic [7:0] r;
        logic       a;
        a = alias_sel;
        alias_sel = 1'b0; bus_read(1'b0, r); check({tag, " ctrl sel0"}, r, ctrl_exp(1'b0));
        alias_sel = 1'b1; bus_read(1'b0, r); check({tag, " ctrl sel1"}, r, ctrl_exp(1'b1));
        alias_sel = a;
        bus_read(1'b1, r); check({tag, " rx byte"}, r, m_buf);
    endtask

    task automatic tx_frame(logic [7:0] d, string tag);
        int base, nb;
        bit has9;
        has9 = m_mode9;
        nb = has9 ? 10 : 9;
        bus_write(1'b1, d);
        base = tick_cnt;
        check({tag, " R4 start low"}, {7'd0, txd}, 8'd0);
        wait_until(base + 8);
        check({tag, " R4 start mid"}, {7'd0, txd}, 8'd0);
        for (int i = 0; i < 8; i++) begin
            wait_until(base + 8 + 16 * (i + 1));
            check($sformatf("%s R4 data bit %0d", tag, i), {7'd0, txd}, {7'd0, d[i]});
            if (i == 2) bus_write(1'b1, ~d);   // R5: ignored while busy
        end
        if (has9) begin
            wait_until(base + 8 + 16 * 9);
            check({tag, " R4 ninth bit"}, {7'd0, txd}, {7'd0, m_tx9});
        end
        wait_until(base + 8 + 16 * nb);
        check({tag, " R4 stop bit"}, {7'd0, txd}, 8'd1);
        m_ti = 1'b1;
        check({tag, " R12 irq on tx done"}, {7'd0, irq}, 8'd1);
        wait_until(base + 16 * (nb + 1) + 4);
        check({tag, " R4 idle high"}, {7'd0, txd}, 8'd1);
        verify_regs({tag, " R5 tx done"});
    endtask

    task automatic model_rx(logic [7:0] d, bit b9, bit stopv);
        if (!m_ren) return;
        if (!m_mode9) begin
            if (!stopv) m_fe = 1'b1;
            if (!m_mp || stopv) begin
                m_buf = d; m_ri = 1'b1;
                if (!m_mp) m_rx9 = stopv;
            end
        end else begin
            if (!m_mp || b9) begin
                m_buf = d; m_ri = 1'b1; m_rx9 = b9;
            end
            if (!stopv) m_fe = 1'b1;
        end
    endtask

    task automatic rx_frame(logic [7:0] d, bit b9, bit stopv, int gbit);
        int base;
        base = tick_cnt;
        rxd = 1'b0;
        wait_until(base + 16);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            if (i == gbit) begin
                wait_until(base + 16 * (i + 1) + 8);
                rxd = ~d[i];
                wait_until(base + 16 * (i + 1) + 9);
                rxd = d[i];
            end
            wait_until(base + 16 * (i + 2));
        end
        if (m_mode9) begin
            rxd = b9;
            wait_until(base + 16 * 10);
        end
        rxd = stopv;
        wait_until(tick_cnt + 16);
        rxd = 1'b1;
        wait_until(tick_cnt + 20);
        model_rx(d, b9, stopv);
    endtask

    initial begin
        logic [7:0] r;
        rst_n = 1'b0; alias_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0;
        bus_wdata = 8'h00; rxd = 1'b1;
        {m_mode9, m_fe, m_lo, m_mp, m_ren, m_tx9, m_rx9, m_ti, m_ri} = '0;
        m_buf = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 txd idle", {7'd0, txd}, 8'd1);
        check("R1 irq low", {7'd0, irq}, 8'd0);
        verify_regs("R1 reset");

        // R2 / R11 alias of bit 7
        alias_sel = 1'b1;
        wr_ctrl(8'h80);
        verify_regs("R2 fe write keeps framing");
        wr_ctrl(8'h00);
        verify_regs("R11 fe software clear");
        alias_sel = 1'b0;
        wr_ctrl(8'h80);
        verify_regs("R2 framing write");
        wr_ctrl(8'h00);

        // R3 / R4 / R5 transmit, 8-bit with bit 6 set
        wr_ctrl(8'h50);
        tx_frame(8'hA5, "R3 8bit aux");
        wr_ctrl(8'h10);
        verify_regs("R13 flags cleared");
        check("R12 irq after clear", {7'd0, irq}, 8'd0);

        // 9-bit transmit with ninth bit 1
        wr_ctrl(8'h98);
        tx_frame(8'h3C, "R3 9bit");
        wr_ctrl(8'h10);

        // R8 8-bit, multiprocessor off
        rx_frame(8'h5A, 1'b0, 1'b1, -1);
        verify_regs("R8 good stop");
        check("R12 irq on rx done", {7'd0, irq}, 8'd1);
        wr_ctrl(8'h10);
        rx_frame(8'hC3, 1'b0, 1'b0, -1);
        verify_regs("R11 R8 bad stop sets fe");

        // R9 8-bit, multiprocessor on
        alias_sel = 1'b1;
        wr_ctrl(8'h30);
        alias_sel = 1'b0;
        rx_frame(8'h11, 1'b0, 1'b0, -1);
        verify_regs("R9 bad stop discarded");
        rx_frame(8'h22, 1'b0, 1'b1, -1);
        verify_regs("R9 good stop accepted");

        // R10 9-bit filtering
        wr_ctrl(8'hB0);
        rx_frame(8'h44, 1'b0, 1'b1, -1);
        verify_regs("R10 ninth 0 discarded");
        rx_frame(8'h66, 1'b1, 1'b1, -1);
        verify_regs("R10 ninth 1 accepted");
        wr_ctrl(8'h90);
        rx_frame(8'h77, 1'b0, 1'b1, -1);
        verify_regs("R10 no filter ninth 0");

        // R7 receiver disabled
        wr_ctrl(8'h00);
        rx_frame(8'h99, 1'b0, 1'b1, -1);
        verify_regs("R7 disabled");

        // R6 start glitch and majority vote
        wr_ctrl(8'h10);
        rxd = 1'b0;
        wait_until(tick_cnt + 3);
        rxd = 1'b1;
        wait_until(tick_cnt + 40);
        verify_regs("R6 start glitch");
        rx_frame(8'h0F, 1'b0, 1'b1, 2);
        verify_regs("R6 one-sample pulse outvoted");

        check("R12 irq tracks flags every clock", irq_bad[7:0], 8'd0);

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule